// File: doc/BRIEF.md
# Programmable Reload Timer

This block is the timing unit of a small 8-bit system. A 16-bit accumulator runs freely on the system clock, and its upper byte is visible as a divider value. An 8-bit event counter steps at one of four rates that are derived from the same accumulator. When the event counter passes its maximum value, it loads itself from a programmable reload register and sends a one-cycle request to an interrupt controller. This gives software a periodic tick whose period it can program.

Software reaches four byte-wide registers through a simple offset-addressed bus. A write takes effect on the clock edge in which `bus_sel` and `bus_wr` are both high. The read data is combinational and always shows the register that `bus_addr` selects. The offsets are: 0 for the divider, 1 for the event counter, 2 for the reload value and 3 for the control register. In the control register, bits 1:0 select the rate and bit 2 enables counting.

Top module: `prog_timer`

## Requirements
- R1: After reset the divider, the event counter, the reload value and the control bits are all zero, the control register reads 0xF8, and `irq_o` is low.
- R2: The control rate code sets the event counter period: 00 gives 1024 clocks, 01 gives 16, 10 gives 64 and 11 gives 256. The counter steps on each edge at which the low log2(period) bits of the accumulator are all ones.
- R3: Control bit 2 enables counting. While it is 0 the event counter holds its value.
- R4: A step taken from 0xFF loads the event counter with the reload value (offset 2) rather than 0.
- R5: Each such overflow raises `irq_o` for exactly one cycle, on the same edge that performs the reload.
- R6: The divider (offset 0) is bits 15:8 of the accumulator. It increments once every 256 clocks and wraps from 0xFF to 0x00.
- R7: A write to offset 0, whatever its data, clears the whole accumulator. The divider then reads 0 and stays 0 for the next 255 clocks.
- R8: The event counter (offset 1) and the reload value (offset 2) can be written, and their current values can be read back at the same offsets.
- R9: If a bus write to the event counter lands on the edge of an overflow, the written data wins over the reload, and `irq_o` still pulses.
- R10: Control bits 7:3 read as ones. A new rate code or enable bit is used from the edge that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | One-cycle overflow request |

## Verification
The assertions assume that the shortest rate period (16 clocks) is longer than one cycle, so two overflow pulses can never fall on adjacent edges. They also assume that the bus holds its inputs stable across each rising edge. The bench changes every input only on the falling clock edge. It draws rate codes only from the four legal selections and biases the reload values toward 0xF0 to 0xFF, so overflows happen often within a short run. Divider clears, control rewrites and counter writes are mixed in at random, so that rate changes and reloads occur in the middle of a period.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    OFS_DIV = 2'd0,
    OFS_CNT = 2'd1,
    OFS_RLD = 2'd2,
    OFS_CTL = 2'd3
  } reg_ofs_e;

  // Pick the log2 period for a rate code.
  function automatic int rate_log(input logic [1:0] sel,
                                  input int l0, input int l1,
                                  input int l2, input int l3);
    case (sel)
      2'd0:    return l0;
      2'd1:    return l1;
      2'd2:    return l2;
      default: return l3;
    endcase
  endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import timer_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int DIV_W = 8,
  parameter int LOG_R0 = 10,
  parameter int LOG_R1 = 4,
  parameter int LOG_R2 = 6,
  parameter int LOG_R3 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [1:0]       rate_sel,
  input  logic             run,
  output logic [DIV_W-1:0] div_o,
  output logic             div_step_o,
  output logic             tick_o
);

  localparam int LOW_W = PRE_W - DIV_W;

  logic [PRE_W-1:0] acc_q;
  logic [PRE_W-1:0] one_w;
  logic [PRE_W-1:0] mask;
  int               lg;

  assign one_w = PRE_W'(1);
  assign lg    = rate_log(rate_sel, LOG_R0, LOG_R1, LOG_R2, LOG_R3);
  assign mask  = (one_w << lg) - one_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else            acc_q <= acc_q + one_w;
  end

  assign div_o      = acc_q[PRE_W-1 -: DIV_W];
  assign div_step_o = &acc_q[LOW_W-1:0];
  assign tick_o     = run && ((acc_q & mask) == mask);

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             ovf_o,
  output logic             irq_o
);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_q, rld_q, cnt_d;
  logic             irq_q;

  assign sum   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign ovf_o = tick && sum[CNT_W];

  always_comb begin
    if (cnt_we)     cnt_d = wdata;
    else if (ovf_o) cnt_d = rld_q;
    else if (tick)  cnt_d = sum[CNT_W-1:0];
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= ovf_o;
      if (rld_we) rld_q <= wdata;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl #(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTL_W-1:0]  wdata,
  output logic [1:0]        rate_sel,
  output logic              run,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int RUN_BIT = 2;

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  assign rate_sel = ctl_q[1:0];
  assign run      = ctl_q[RUN_BIT];
  assign rd_byte  = {{(DATA_W-CTL_W){1'b1}}, ctl_q};

endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 2,
  parameter int LOG_R0 = 10,
  parameter int LOG_R1 = 4,
  parameter int LOG_R2 = 6,
  parameter int LOG_R3 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  localparam int CTL_W = 3;
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(OFS_DIV);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFS_RLD);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);

  logic              bus_we, div_we, cnt_we, rld_we, ctl_we;
  logic              tick, ovf, run, div_step;
  logic [1:0]        rate_sel;
  logic [DATA_W-1:0] div_val, cnt_val, rld_val, ctl_val;

  assign bus_we = bus_sel && bus_wr;
  assign div_we = bus_we && (bus_addr == A_DIV);
  assign cnt_we = bus_we && (bus_addr == A_CNT);
  assign rld_we = bus_we && (bus_addr == A_RLD);
  assign ctl_we = bus_we && (bus_addr == A_CTL);

  timer_ctrl #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(bus_wdata[CTL_W-1:0]),
    .rate_sel(rate_sel), .run(run), .rd_byte(ctl_val)
  );

  timer_prescaler #(
    .PRE_W(PRE_W), .DIV_W(DATA_W),
    .LOG_R0(LOG_R0), .LOG_R1(LOG_R1), .LOG_R2(LOG_R2), .LOG_R3(LOG_R3)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(div_we), .rate_sel(rate_sel), .run(run),
    .div_o(div_val), .div_step_o(div_step), .tick_o(tick)
  );

  timer_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .rld_we(rld_we),
    .wdata(bus_wdata), .cnt_o(cnt_val), .rld_o(rld_val), .ovf_o(ovf),
    .irq_o(irq_o)
  );

  always_comb begin
    case (bus_addr)
      A_DIV:   bus_rdata = div_val;
      A_CNT:   bus_rdata = cnt_val;
      A_RLD:   bus_rdata = rld_val;
      A_CTL:   bus_rdata = ctl_val;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic              div_we,
  input logic              cnt_we,
  input logic              div_step,
  input logic              tick,
  input logic              ovf,
  input logic              run,
  input logic [DATA_W-1:0] div_val,
  input logic [DATA_W-1:0] cnt_val,
  input logic [DATA_W-1:0] rld_val
);

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq_o);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_we) |=> (cnt_val == $past(rld_val)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_val == $past(bus_wdata)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_val));

  assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  assert_div_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> (div_val == '0));

  assert_div_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_we && div_step) |=> (div_val == DATA_W'($past(div_val) + 1'b1)));

  assert_ctl_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(3)) |-> (&bus_rdata[DATA_W-1:3]));

endmodule

bind prog_timer timer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .div_we(div_we), .cnt_we(cnt_we),
  .div_step(div_step), .tick(tick), .ovf(ovf), .run(run),
  .div_val(div_val), .cnt_val(cnt_val), .rld_val(rld_val)
);

// File: tb/sim_prog_timer.sv
`timescale 1ns/1ps
module sim_prog_timer;

  localparam int HALF = 4;  // 125 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #HALF clk = ~clk;

  prog_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // ---------------- reference model built from the requirements
  logic [15:0] m_acc;
  logic [7:0]  m_cnt, m_rld;
  logic [2:0]  m_ctl;
  logic        m_irq;

  function automatic int period_of(input logic [1:0] code);
    case (code)
      2'd0: return 1024;
      2'd1: return 16;
      2'd2: return 64;
      default: return 256;
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_acc / 256;
      2'd1: return m_cnt;
      2'd2: return m_rld;
      default: return {5'b11111, m_ctl};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= 16'd0; m_cnt <= 8'd0; m_rld <= 8'd0; m_ctl <= 3'd0; m_irq <= 1'b0;
    end else begin
      logic we, stepping;
      we = bus_sel && bus_wr;
      stepping = m_ctl[2] && ((int'(m_acc) % period_of(m_ctl[1:0])) == period_of(m_ctl[1:0]) - 1);
      m_irq <= stepping && (m_cnt == 8'hFF);
      m_acc <= (we && bus_addr == 2'd0) ? 16'd0 : m_acc + 16'd1;
      if (we && bus_addr == 2'd1) m_cnt <= bus_wdata;
      else if (stepping)          m_cnt <= (m_cnt == 8'hFF) ? m_rld : m_cnt + 8'd1;
      if (we && bus_addr == 2'd2) m_rld <= bus_wdata;
      if (we && bus_addr == 2'd3) m_ctl <= bus_wdata[2:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      check("R5 irq vs model", irq_o, m_irq);
      case (bus_addr)
        2'd0: check("R6 divider vs model", bus_rdata, model_read(bus_addr));
        2'd1: check("R8 counter vs model", bus_rdata, model_read(bus_addr));
        2'd2: check("R8 reload vs model", bus_rdata, model_read(bus_addr));
        default: check("R10 control vs model", bus_rdata, model_read(bus_addr));
      endcase
    end
  end

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, 8'h00, "R1 divider");
    peek(2'd1, 8'h00, "R1 counter");
    peek(2'd2, 8'h00, "R1 reload");
    peek(2'd3, 8'hF8, "R1 control");
    check("R1 irq", irq_o, 1'b0);

    // R6 divider after 256 clocks
    repeat (255) @(negedge clk);
    peek(2'd0, 8'h00, "R6 divider at 255");
    @(negedge clk);
    peek(2'd0, 8'h01, "R6 divider at 256");

    // R7 divider clear
    wr(2'd0, 8'h5A);
    peek(2'd0, 8'h00, "R7 divider cleared");
    repeat (255) @(negedge clk);
    peek(2'd0, 8'h00, "R7 divider still zero");
    @(negedge clk);
    peek(2'd0, 8'h01, "R7 divider first step");

    // R10 control readback
    wr(2'd3, 8'h06);
    peek(2'd3, 8'hFE, "R10 control ones");

    // R2 each rate code
    for (int s = 0; s < 4; s++) begin
      int p;
      p = period_of(2'(s));
      wr(2'd3, 8'(4 | s));
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      repeat (2 * p - 2) @(negedge clk);
      peek(2'd1, 8'h01, "R2 one step");
      @(negedge clk);
      peek(2'd1, 8'h02, "R2 two steps");
    end

    // R4 / R5 overflow with reload
    wr(2'd3, 8'h00);
    wr(2'd2, 8'hA5);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h05);
    repeat (14) @(negedge clk);
    peek(2'd1, 8'hFF, "R4 before overflow");
    check("R5 irq low before", irq_o, 1'b0);
    @(negedge clk);
    check("R5 irq pulse", irq_o, 1'b1);
    peek(2'd1, 8'hA5, "R4 reloaded");
    @(negedge clk);
    check("R5 irq one cycle", irq_o, 1'b0);

    // R9 write wins over reload
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h05);
    repeat (14) @(negedge clk);
    wr(2'd1, 8'h33);
    check("R9 irq still pulses", irq_o, 1'b1);
    peek(2'd1, 8'h33, "R9 write wins");

    // R3 disabled holds
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h40);
    repeat (200) @(negedge clk);
    peek(2'd1, 8'h40, "R3 counter held");

    // random phase checked by the model
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 8) == 0) begin
        case ($urandom % 8)
          0: wr(2'd0, 8'($urandom));
          1, 2: wr(2'd3, (($urandom % 5) == 0) ? 8'($urandom) : 8'(4 | ($urandom % 4)));
          3: wr(2'd1, 8'($urandom));
          4, 5: wr(2'd2, 8'(8'hF0 | ($urandom % 16)));
          default: wr(2'd1, 8'(8'hF8 | ($urandom % 8)));
        endcase
      end else begin
        bus_addr = 2'($urandom % 4);
        @(negedge clk);
      end
    end

    summary();
    $finish;
  end

endmodule